// File: doc/BRIEF.md
# Mode-0 Parallel I/O Port Controller

This block gives a chip's register bus 24 general-purpose I/O lines grouped as two full byte ports (A and B) and one byte port (C) whose upper and lower nibbles are steered independently. A single control byte sets each of the four groups (A, B, C-upper, C-lower) to drive or to listen. Every line has its own output value and output enable toward the pad ring, and every line's input passes through a two-flop synchroniser before the read path.

Software sees four byte registers behind a two-bit offset. Writing a data offset loads that port's output latch. Reading a data offset returns, bit by bit, the latch for lines that drive and the synchronised pin level for lines that listen. A valid control write changes the directions and clears every output latch, so no line starts driving an old value. Handshake modes, bit set/reset commands and pad electrical behaviour are not part of this block.

Top module: `pio24_top`

## Requirements
- R1: After reset all 24 output enables are 0, all output latches (pinOut) are 0 and busRdData is 0x00.
- R2: A write to offset 0, 1 or 2 loads the whole byte into the latch of port A, B or C respectively. The latch appears on pinOut (A on bits 7:0, B on 15:8, C on 23:16) one clock later, whatever the direction of the group.
- R3: In an accepted control byte, bit 4 sets port A, bit 3 sets C-upper (pins 23:20), bit 1 sets port B and bit 0 sets C-lower (pins 19:16). A 1 makes the group an input (enables 0) and a 0 makes it an output (enables 1). The new enables take effect one clock after the write. For example, 0x80 sets all groups to output and 0x9B sets all groups to input.
- R4: A control write is accepted only when bit 7 is 1 and bits 6, 5 and 2 are 0. Any other byte written to offset 3 leaves the directions and all latches unchanged.
- R5: Every accepted control write clears all 24 output latches to 0 in the same clock that applies the new directions.
- R6: Reading a port group configured as output returns its latch value.
- R7: Reading a port group configured as input returns the pin level after a two-flop synchroniser. A pin level held for at least three clocks before the read cycle is returned, and a later pin change is reflected by the next such read; nothing is latched.
- R8: Port C is read as one byte whose upper nibble follows the C-upper direction and whose lower nibble follows the C-lower direction.
- R9: A read of offset 3 returns 0x00.
- R10: Read data is registered: busRdData shows the value one clock after the cycle with busRdEn high and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 2 | Register offset: 0 port A, 1 port B, 2 port C, 3 control |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | 8 | Write data |
| busRdEn | input | 1 | Read strobe, one cycle per read |
| busRdData | output | 8 | Registered read data |
| pinIn | input | 24 | Pad input levels (asynchronous) |
| pinOut | output | 24 | Output latch values toward the pads |
| pinOe | output | 24 | Per-line output enable, 1 = drive |

## Verification
The assertions assume that a write and a read are never requested in the same cycle and that the strobes are single-cycle. They treat pin levels as valid only after they have been stable for longer than the synchroniser depth. The stimulus meets these assumptions: every bus access is issued as a one-cycle pulse from a task, writes and reads never overlap, and a new pin pattern is held for three clocks before any read that checks it. Random control bytes mix legal encodings with illegal ones, so both the accept path and the ignore path of offset 3 are exercised.

// File: rtl/pio24_pkg.sv
package pio24_pkg;
  localparam int DATA_W  = 8;
  localparam int NUM_PORTS = 3;
  localparam int LINE_W  = DATA_W * NUM_PORTS;
  localparam int NIB_W   = DATA_W / 2;

  localparam logic [1:0] OFF_A   = 2'd0;
  localparam logic [1:0] OFF_B   = 2'd1;
  localparam logic [1:0] OFF_C   = 2'd2;
  localparam logic [1:0] OFF_CFG = 2'd3;

  // strobes from control to datapath
  typedef struct packed {
    logic       wrA;
    logic       wrB;
    logic       wrC;
    logic       clrLatch;
    logic       rdEn;
    logic [1:0] rdSel;
  } pioStrobe_t;

  // 1 = group listens
  typedef struct packed {
    logic inA;
    logic inCu;
    logic inB;
    logic inCl;
  } pioDir_t;
endpackage

// File: rtl/pio24_ctrl.sv
module pio24_ctrl
  import pio24_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [DATA_W-1:0] busWrData,
  output pioStrobe_t        strobe,
  output pioDir_t           dir
);
  logic cfgLegal;
  logic cfgHit;
  pioDir_t dirQ;

  // mode-set flag high, reserved mode bits low
  assign cfgLegal = busWrData[7] & ~busWrData[6] & ~busWrData[5] & ~busWrData[2];
  assign cfgHit   = busWrEn && (busAddr == OFF_CFG) && cfgLegal;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirQ <= '1;
    end else if (cfgHit) begin
      dirQ.inA  <= busWrData[4];
      dirQ.inCu <= busWrData[3];
      dirQ.inB  <= busWrData[1];
      dirQ.inCl <= busWrData[0];
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.wrA      = busWrEn && (busAddr == OFF_A);
    strobe.wrB      = busWrEn && (busAddr == OFF_B);
    strobe.wrC      = busWrEn && (busAddr == OFF_C);
    strobe.clrLatch = cfgHit;
    strobe.rdEn     = busRdEn;
    strobe.rdSel    = busAddr;
  end

  assign dir = dirQ;
endmodule

// File: rtl/pio24_datapath.sv
module pio24_datapath
  import pio24_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  pioStrobe_t        strobe,
  input  pioDir_t           dir,
  input  logic [DATA_W-1:0] busWrData,
  input  logic [LINE_W-1:0] pinIn,
  output logic [LINE_W-1:0] pinOut,
  output logic [LINE_W-1:0] pinOe,
  output logic [DATA_W-1:0] busRdData
);
  localparam int LAST_STAGE = SYNC_STAGES - 1;

  logic [NUM_PORTS-1:0] wrVec;
  logic [LINE_W-1:0]    latchAll;
  logic [LINE_W-1:0]    inMask;
  logic [LINE_W-1:0]    viewAll;
  logic [LINE_W-1:0]    syncQ [SYNC_STAGES];
  logic [DATA_W-1:0]    rdNext;
  logic [DATA_W-1:0]    rdQ;

  assign wrVec = {strobe.wrC, strobe.wrB, strobe.wrA};

  // one output latch per port
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [DATA_W-1:0] latchQ;
    always_ff @(posedge clk) begin
      if (!rstN || strobe.clrLatch) latchQ <= '0;
      else if (wrVec[p])            latchQ <= busWrData;
    end
    assign latchAll[p*DATA_W +: DATA_W] = latchQ;
  end

  // input synchroniser chain
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rstN) syncQ[s] <= '0;
      else if (s == 0) syncQ[s] <= pinIn;
      else syncQ[s] <= syncQ[(s == 0) ? 0 : s-1];
    end
  end

  assign inMask = {{NIB_W{dir.inCu}}, {NIB_W{dir.inCl}},
                   {DATA_W{dir.inB}}, {DATA_W{dir.inA}}};
  assign viewAll = (inMask & syncQ[LAST_STAGE]) | (~inMask & latchAll);

  always_comb begin
    case (strobe.rdSel)
      OFF_A:   rdNext = viewAll[0 +: DATA_W];
      OFF_B:   rdNext = viewAll[DATA_W +: DATA_W];
      OFF_C:   rdNext = viewAll[2*DATA_W +: DATA_W];
      default: rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)            rdQ <= '0;
    else if (strobe.rdEn) rdQ <= rdNext;
  end

  assign pinOut    = latchAll;
  assign pinOe     = ~inMask;
  assign busRdData = rdQ;
endmodule

// File: rtl/pio24_top.sv
module pio24_top
  import pio24_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        busAddr,
  input  logic              busWrEn,
  input  logic [7:0]        busWrData,
  input  logic              busRdEn,
  output logic [7:0]        busRdData,
  input  logic [23:0]       pinIn,
  output logic [23:0]       pinOut,
  output logic [23:0]       pinOe
);
  pioStrobe_t strobe;
  pioDir_t    dir;

  pio24_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .strobe(strobe), .dir(dir)
  );

  pio24_datapath #(.SYNC_STAGES(SYNC_STAGES)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dir(dir),
    .busWrData(busWrData), .pinIn(pinIn), .pinOut(pinOut),
    .pinOe(pinOe), .busRdData(busRdData)
  );
endmodule

// File: rtl/pio24_checker.sv
module pio24_checker (
  input logic        clk,
  input logic        rstN,
  input logic [1:0]  busAddr,
  input logic        busWrEn,
  input logic [7:0]  busWrData,
  input logic        busRdEn,
  input logic [7:0]  busRdData,
  input logic [23:0] pinOut,
  input logic [23:0] pinOe
);
  logic legalCfg;
  assign legalCfg = busWrData[7] & ~busWrData[6] & ~busWrData[5] & ~busWrData[2];

  // R2
  port_a_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn && busAddr == 2'd0 |=> pinOut[7:0] == $past(busWrData));

  // R3
  dir_a_apply_chk: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn && busAddr == 2'd3 && legalCfg |=> pinOe[7:0] == {8{~$past(busWrData[4])}});

  // R3
  dir_cl_apply_chk: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn && busAddr == 2'd3 && legalCfg |=> pinOe[19:16] == {4{~$past(busWrData[0])}});

  // R4
  bad_cfg_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn && busAddr == 2'd3 && !legalCfg |=> $stable(pinOe) && $stable(pinOut));

  // R5
  cfg_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn && busAddr == 2'd3 && legalCfg |=> pinOut == 24'h0);

  // R6
  out_readback_chk: assert property (@(posedge clk) disable iff (!rstN)
    busRdEn && !busWrEn && busAddr == 2'd1 && pinOe[8] |=> busRdData == $past(pinOut[15:8]));

  // R9
  cfg_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    busRdEn && busAddr == 2'd3 |=> busRdData == 8'h00);

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busRdEn |=> $stable(busRdData));
endmodule

bind pio24_top pio24_checker i_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
  .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(busRdData),
  .pinOut(pinOut), .pinOe(pinOe)
);

// File: tb/test_pio24_top.sv
module test_pio24_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [7:0]  busWrData = '0;
  logic        busRdEn = 1'b0;
  logic [7:0]  busRdData;
  logic [23:0] pinIn = '0;
  logic [23:0] pinOut;
  logic [23:0] pinOe;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // reference model state
  logic [7:0] mLat [3];
  logic       mInA, mInB, mInCu, mInCl;
  logic [23:0] mPins;

  always #4 clk = ~clk;

  pio24_top i_pio24_top (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(busRdData),
    .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe)
  );

  task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic legal(input logic [7:0] d);
    return d[7] & ~d[6] & ~d[5] & ~d[2];
  endfunction

  function automatic logic [23:0] expOe();
    return ~{{4{mInCu}}, {4{mInCl}}, {8{mInB}}, {8{mInA}}};
  endfunction

  function automatic logic [23:0] expOut();
    return {mLat[2], mLat[1], mLat[0]};
  endfunction

  function automatic logic [7:0] expRead(input logic [1:0] a);
    logic [23:0] m = ~expOe();
    logic [23:0] v = (m & mPins) | (~m & expOut());
    case (a)
      2'd0: return v[7:0];
      2'd1: return v[15:8];
      2'd2: return v[23:16];
      default: return 8'h00;
    endcase
  endfunction

  task automatic modelReset();
    for (int i = 0; i < 3; i++) mLat[i] = '0;
    mInA = 1; mInB = 1; mInCu = 1; mInCl = 1;
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
    if (a == 2'd3) begin
      if (legal(d)) begin
        mInA = d[4]; mInCu = d[3]; mInB = d[1]; mInCl = d[0];
        for (int i = 0; i < 3; i++) mLat[i] = '0;
      end
    end else begin
      mLat[a] = d;
    end
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    @(negedge clk);
    busRdEn = 1'b0;
    v = busRdData;
  endtask

  task automatic setPins(input logic [23:0] p);
    @(negedge clk);
    pinIn = p; mPins = p;
    repeat (3) @(negedge clk);
  endtask

  task automatic checkPins(input string tag);
    check({tag, " oe"}, pinOe, expOe());
    check({tag, " out"}, pinOut, expOut());
  endtask

  task automatic checkRead(input string tag, input logic [1:0] a);
    logic [7:0] v;
    rdReg(a, v);
    check(tag, {16'h0, v}, {16'h0, expRead(a)});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] v;
    logic [7:0] held;
    void'($urandom(32'd4242));
    modelReset();
    mPins = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 oe after reset", pinOe, 24'h0);
    check("R1 out after reset", pinOut, 24'h0);
    check("R1 rdData after reset", {16'h0, busRdData}, 24'h0);

    // R7 inputs at reset, R8 port C mixed
    setPins(24'hA5_3C_96);
    checkRead("R7 port A input", 2'd0);
    checkRead("R8 port C input", 2'd2);
    setPins(24'h5A_C3_69);
    checkRead("R7 port A pin change not latched", 2'd0);

    // R3 all outputs, R2 latches
    wrReg(2'd3, 8'h80);
    checkPins("R3 cfg 0x80");
    wrReg(2'd0, 8'h11); wrReg(2'd1, 8'h22); wrReg(2'd2, 8'h33);
    checkPins("R2 latch load");
    checkRead("R6 port B readback", 2'd1);
    checkRead("R6 port C readback", 2'd2);

    // R10 hold after read
    held = busRdData;
    repeat (4) @(negedge clk);
    check("R10 read data held", {16'h0, busRdData}, {16'h0, held});

    // R4 illegal control bytes ignored
    wrReg(2'd3, 8'h00); checkPins("R4 cfg 0x00 ignored");
    wrReg(2'd3, 8'h9F); checkPins("R4 cfg bit2 ignored");
    wrReg(2'd3, 8'hC0); checkPins("R4 cfg bit6 ignored");
    wrReg(2'd3, 8'hA0); checkPins("R4 cfg bit5 ignored");

    // R5 clear, R8 split port C
    wrReg(2'd3, 8'h89);  // A out, Cu in, B out, Cl in
    checkPins("R5 cfg 0x89 clears latches");
    wrReg(2'd2, 8'hF0);
    setPins(24'h0C_00_00);
    checkRead("R8 port C split nibbles", 2'd2);
    wrReg(2'd3, 8'h82);
    checkPins("R3 cfg 0x82 B input");
    wrReg(2'd1, 8'h77);
    checkPins("R2 write to input port loads latch");
    checkRead("R7 port B input ignores latch", 2'd1);

    // R9
    checkRead("R9 offset 3 reads zero", 2'd3);
    wrReg(2'd3, 8'h9B);
    checkPins("R3 cfg 0x9B all input");

    // random mix
    for (int it = 0; it < 400; it++) begin
      int op = $urandom_range(0, 4);
      case (op)
        0: begin
          logic [7:0] d = {1'b1, 2'b00, 2'($urandom), 1'b0, 2'($urandom)};
          wrReg(2'd3, d);
          checkPins("R3 R5 random cfg");
        end
        1: begin
          wrReg(2'd3, 8'($urandom));
          checkPins("R4 random cfg byte");
        end
        2: begin
          wrReg(2'($urandom_range(0, 2)), 8'($urandom));
          checkPins("R2 random port write");
        end
        3: setPins(24'($urandom));
        default: checkRead("R6 R7 R8 R9 random read", 2'($urandom));
      endcase
    end

    rdReg(2'd0, v);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule